// File: doc/BRIEF.md
# Flat page-table address translator

This block turns 32-bit I/O virtual addresses into physical addresses for a 4 GB virtual space split into 4 KB pages. The mapping lives in memory as a flat, single-level array of 2^20 32-bit descriptors (4 MB in total). The array is indexed directly by virtual address bits [31:12], and its start address comes from a base register that software writes.

A client presents one virtual address at a time. A small fully associative TLB holds recent translations and answers a hit one cycle after the request is accepted. On a miss the block issues a single memory read for the descriptor, waits for the data, and then answers. A usable descriptor is also cached. A descriptor whose valid flag is clear produces a translation fault that carries the faulting virtual address. Writing the base register drops every cached translation.

Top module: `pgtbl_xlate`

## Requirements
- R1: After reset, req_ready_o is 1, rsp_valid_o and mem_req_valid_o are 0, and the TLB is empty, so the first request always misses.
- R2: On a miss, exactly one memory read is issued, at address base + (va[31:12] << 2). mem_req_valid_o and mem_req_addr_o stay unchanged until mem_req_ready_i is seen.
- R3: For a descriptor with bit 1 set, the response appears in the cycle after mem_rsp_valid_i, with rsp_addr_o = {desc[31:12], va[11:0]}, rsp_nonsec_o = desc[3] and rsp_fault_o = 0.
- R4: For a descriptor with bit 1 clear, whether it is all zeros or not, the response has rsp_fault_o = 1, rsp_addr_o = the virtual address and rsp_nonsec_o = 0. No TLB entry is filled, so the same page misses again.
- R5: A request whose page is cached is answered in the cycle after acceptance, with the cached translation and no memory read.
- R6: Only one miss can be in flight. req_ready_o is 0 from the cycle after a miss is accepted until the response cycle.
- R7: The TLB holds 8 entries and replaces them in round-robin order. Filling a 9th page evicts the oldest page, and the remaining pages still hit.
- R8: A write to the base register invalidates every TLB entry. Later walks use the new base.
- R9: A request accepted in the same cycle as a base write is handled as a miss, and its read uses the newly written base.
- R10: If a base write occurs while a miss is in flight, that miss still returns its response, but its result is not cached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Base register write strobe |
| cfg_wdata_i | input | 32 | New table base address |
| req_valid_i | input | 1 | Translation request valid |
| req_va_i | input | 32 | Virtual address to translate |
| req_ready_o | output | 1 | Block can accept a request |
| rsp_valid_o | output | 1 | Response valid (one-cycle pulse) |
| rsp_addr_o | output | 32 | Physical address, or the virtual address on a fault |
| rsp_fault_o | output | 1 | Translation fault |
| rsp_nonsec_o | output | 1 | Mapping is marked non-secure |
| mem_req_valid_o | output | 1 | Descriptor read request |
| mem_req_addr_o | output | 32 | Descriptor byte address |
| mem_req_ready_i | input | 1 | Memory accepts the read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Descriptor word |

## Verification
The bench builds the block with its default of 8 TLB entries and 32-bit addresses. With 8 entries, the round-robin pointer can be driven through a full wrap by filling nine distinct pages, which makes eviction of the oldest page observable at the ports. Descriptor memory is modelled behaviourally with delayed acceptance and late base writes, so the cases where a base write meets a lookup or an in-flight walk can be reached.

// File: rtl/xlate_pkg.sv
`timescale 1ns/1ps
package xlate_pkg;
  localparam int unsigned ADDR_W       = 32;
  localparam int unsigned PG_SHIFT     = 12;
  localparam int unsigned VPN_W        = ADDR_W - PG_SHIFT;
  localparam int unsigned DESC_VLD_BIT = 1;
  localparam int unsigned DESC_NS_BIT  = 3;

  typedef enum logic [1:0] {WK_IDLE, WK_REQ, WK_WAIT} wk_state_e;

  typedef struct packed {
    logic [VPN_W-1:0] vpn;
    logic [VPN_W-1:0] ppn;
    logic             ns;
  } tlb_ent_t;
endpackage

// File: rtl/xlate_tlb.sv
`timescale 1ns/1ps
module xlate_tlb
  import xlate_pkg::*;
#(
  parameter  int unsigned ENTRIES = 8,
  localparam int unsigned IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flush_i,
  input  logic [VPN_W-1:0]   lk_vpn_i,
  output logic               hit_o,
  output tlb_ent_t           hit_ent_o,
  input  logic               fill_i,
  input  tlb_ent_t           fill_ent_i,
  output logic [ENTRIES-1:0] vld_o
);
  tlb_ent_t           ent_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] match;
  logic [IDX_W-1:0]   rr_q;
  logic               do_fill;

  assign do_fill = fill_i && !flush_i;  // flush wins

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = vld_q[g] && (ent_q[g].vpn == lk_vpn_i);
  end

  always_comb begin
    hit_ent_o = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match[i]) hit_ent_o = tlb_ent_t'(hit_ent_o | ent_q[i]);
  end

  assign hit_o = |match;
  assign vld_o = vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) ent_q[i] <= '0;
    end else if (do_fill) begin
      for (int i = 0; i < ENTRIES; i++)
        if (rr_q == IDX_W'(i)) ent_q[i] <= fill_ent_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else if (flush_i) begin
      vld_q <= '0;
    end else if (do_fill) begin
      vld_q[rr_q] <= 1'b1;
      rr_q        <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/xlate_walk.sv
`timescale 1ns/1ps
module xlate_walk
  import xlate_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              flush_i,
  output logic              busy_o,
  output logic              mem_req_valid_o,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  input  logic              mem_req_ready_i,
  input  logic              mem_rsp_valid_i,
  input  logic [ADDR_W-1:0] mem_rsp_data_i,
  output logic              done_o,
  output logic [ADDR_W-1:0] desc_o,
  output logic              stale_o
);
  wk_state_e         state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              stale_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WK_IDLE;
      addr_q  <= '0;
      stale_q <= 1'b0;
    end else begin
      unique case (state_q)
        WK_IDLE: if (start_i) begin
          state_q <= WK_REQ;
          addr_q  <= addr_i;
        end
        WK_REQ:  if (mem_req_ready_i) state_q <= WK_WAIT;
        WK_WAIT: if (mem_rsp_valid_i) state_q <= WK_IDLE;
        default: state_q <= WK_IDLE;
      endcase
      // a walk started alongside a base write already uses the new base
      if (start_i)                stale_q <= 1'b0;
      else if (busy_o && flush_i) stale_q <= 1'b1;
    end
  end

  assign busy_o          = (state_q != WK_IDLE);
  assign mem_req_valid_o = (state_q == WK_REQ);
  assign mem_req_addr_o  = addr_q;
  assign done_o          = (state_q == WK_WAIT) && mem_rsp_valid_i;
  assign desc_o          = mem_rsp_data_i;
  assign stale_o         = stale_q || flush_i;
endmodule

// File: rtl/pgtbl_xlate.sv
`timescale 1ns/1ps
module pgtbl_xlate
  import xlate_pkg::*;
#(
  parameter int unsigned TLB_ENTRIES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_va_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic [ADDR_W-1:0] rsp_addr_o,
  output logic              rsp_fault_o,
  output logic              rsp_nonsec_o,
  output logic              mem_req_valid_o,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  input  logic              mem_req_ready_i,
  input  logic              mem_rsp_valid_i,
  input  logic [ADDR_W-1:0] mem_rsp_data_i
);
  localparam int unsigned PAD_W = ADDR_W - VPN_W - 2;

  logic [ADDR_W-1:0]      base_q, base_eff, walk_addr, desc, va_q;
  logic [VPN_W-1:0]       req_vpn;
  logic                   acc, tlb_hit, hit_eff, miss;
  logic                   walk_busy, walk_done, walk_stale, desc_ok, fill;
  logic [TLB_ENTRIES-1:0] tlb_vld;
  tlb_ent_t               hit_ent, fill_ent;
  logic                   unused_sink;

  assign base_eff    = cfg_we_i ? cfg_wdata_i : base_q;
  assign req_vpn     = req_va_i[ADDR_W-1:PG_SHIFT];
  assign req_ready_o = !walk_busy;
  assign acc         = req_valid_i && req_ready_o;
  assign hit_eff     = tlb_hit && !cfg_we_i;
  assign miss        = acc && !hit_eff;
  assign walk_addr   = base_eff + {{PAD_W{1'b0}}, req_vpn, 2'b00};
  assign desc_ok     = desc[DESC_VLD_BIT];
  assign fill        = walk_done && desc_ok && !walk_stale;
  assign fill_ent    = '{vpn: va_q[ADDR_W-1:PG_SHIFT],
                         ppn: desc[ADDR_W-1:PG_SHIFT],
                         ns:  desc[DESC_NS_BIT]};
  assign unused_sink = ^{desc[PG_SHIFT-1:DESC_NS_BIT+1], desc[2], desc[0], tlb_vld};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) base_q <= '0;
    else if (cfg_we_i) base_q <= cfg_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) va_q <= '0;
    else if (acc) va_q <= req_va_i;
  end

  xlate_tlb #(.ENTRIES(TLB_ENTRIES)) u_tlb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (cfg_we_i),
    .lk_vpn_i   (req_vpn),
    .hit_o      (tlb_hit),
    .hit_ent_o  (hit_ent),
    .fill_i     (fill),
    .fill_ent_i (fill_ent),
    .vld_o      (tlb_vld)
  );

  xlate_walk u_walk (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .start_i         (miss),
    .addr_i          (walk_addr),
    .flush_i         (cfg_we_i),
    .busy_o          (walk_busy),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_addr_o  (mem_req_addr_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .mem_rsp_data_i  (mem_rsp_data_i),
    .done_o          (walk_done),
    .desc_o          (desc),
    .stale_o         (walk_stale)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_addr_o   <= '0;
      rsp_fault_o  <= 1'b0;
      rsp_nonsec_o <= 1'b0;
    end else begin
      rsp_valid_o <= 1'b0;
      if (acc && hit_eff) begin
        rsp_valid_o  <= 1'b1;
        rsp_addr_o   <= {hit_ent.ppn, req_va_i[PG_SHIFT-1:0]};
        rsp_fault_o  <= 1'b0;
        rsp_nonsec_o <= hit_ent.ns;
      end else if (walk_done) begin
        rsp_valid_o  <= 1'b1;
        rsp_addr_o   <= desc_ok ? {desc[ADDR_W-1:PG_SHIFT], va_q[PG_SHIFT-1:0]} : va_q;
        rsp_fault_o  <= !desc_ok;
        rsp_nonsec_o <= desc_ok && desc[DESC_NS_BIT];
      end
    end
  end
endmodule

// File: rtl/pgtbl_xlate_chk.sv
`timescale 1ns/1ps
module pgtbl_xlate_chk #(
  parameter int unsigned N = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         cfg_we_i,
  input logic         req_valid_i,
  input logic         req_ready_o,
  input logic         rsp_valid_o,
  input logic         rsp_fault_o,
  input logic         rsp_nonsec_o,
  input logic         mem_req_valid_o,
  input logic         mem_req_ready_i,
  input logic [31:0]  mem_req_addr_o,
  input logic         mem_rsp_valid_i,
  input logic [N-1:0] tlb_vld
);
  // R6
  one_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !req_ready_o);
  // R6
  rsp_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !rsp_valid_o);
  // R2
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));
  // R8
  flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> tlb_vld == '0);
  // R3
  rsp_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(req_valid_i && req_ready_o) || $past(mem_rsp_valid_i));
  // R4
  fault_ns_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fault_o |-> !rsp_nonsec_o);
endmodule

bind pgtbl_xlate pgtbl_xlate_chk #(.N(TLB_ENTRIES)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .cfg_we_i        (cfg_we_i),
  .req_valid_i     (req_valid_i),
  .req_ready_o     (req_ready_o),
  .rsp_valid_o     (rsp_valid_o),
  .rsp_fault_o     (rsp_fault_o),
  .rsp_nonsec_o    (rsp_nonsec_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_addr_o  (mem_req_addr_o),
  .mem_rsp_valid_i (mem_rsp_valid_i),
  .tlb_vld         (tlb_vld)
);

// File: tb/pgtbl_xlate_tb_top.sv
`timescale 1ns/1ps
module pgtbl_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic        req_ready, rsp_valid, rsp_fault, rsp_ns, mem_req_valid;
  logic [31:0] rsp_addr, mem_req_addr;
  logic        mem_req_ready = 1'b0;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int n_tests = 0;
  int n_fail  = 0;

  bit [31:0] mem [bit [31:0]];
  bit [31:0] m_base = '0;
  bit [19:0] m_vpn [8];
  bit        m_v [8];
  bit [31:0] m_desc [8];
  int        m_ptr = 0;

  always #2.5 clk = ~clk;

  pgtbl_xlate dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .req_valid_i(req_valid), .req_va_i(req_va), .req_ready_o(req_ready),
    .rsp_valid_o(rsp_valid), .rsp_addr_o(rsp_addr), .rsp_fault_o(rsp_fault),
    .rsp_nonsec_o(rsp_ns),
    .mem_req_valid_o(mem_req_valid), .mem_req_addr_o(mem_req_addr),
    .mem_req_ready_i(mem_req_ready), .mem_rsp_valid_i(mem_rsp_valid),
    .mem_rsp_data_i(mem_rsp_data)
  );

  function automatic bit [31:0] rd(input bit [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", rq, what, act, exp);
    end
  endtask

  task automatic m_flush(input bit [31:0] nb);
    for (int i = 0; i < 8; i++) m_v[i] = 1'b0;
    m_base = nb;
  endtask

  task automatic cfg_write(input bit [31:0] nb);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = nb;
    @(negedge clk);
    cfg_we = 1'b0;
    m_flush(nb);
  endtask

  // one translation; wr_same/wr_mid place a base write at accept or during the walk
  task automatic xlate(input bit [31:0] va, input string rq, input int stall = 0,
                       input bit wr_same = 0, input bit wr_mid = 0,
                       input bit [31:0] wr_val = 0, input int exp_hit = -1);
    bit        hit = 0;
    bit        stale = 0;
    bit [31:0] d = 0;
    bit [31:0] exp_pa;
    bit [19:0] vpn = va[31:12];
    @(negedge clk);
    req_valid = 1'b1; req_va = va;
    if (wr_same) begin cfg_we = 1'b1; cfg_wdata = wr_val; m_flush(wr_val); end
    for (int i = 0; i < 8; i++) if (m_v[i] && m_vpn[i] == vpn) begin hit = 1; d = m_desc[i]; end
    if (exp_hit >= 0) chk(rq, "model hit expectation", 32'(hit), 32'(exp_hit));
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    if (hit) begin
      chk(rq, "hit rsp_valid", 32'(rsp_valid), 1);
      chk(rq, "hit no mem read", 32'(mem_req_valid), 0);
      chk(rq, "hit addr", rsp_addr, {d[31:12], va[11:0]});
      chk(rq, "hit nonsec", 32'(rsp_ns), 32'(d[3]));
      chk(rq, "hit fault", 32'(rsp_fault), 0);
      return;
    end
    chk(rq, "miss mem_req_valid", 32'(mem_req_valid), 1);
    chk(rq, "miss rsp_valid low", 32'(rsp_valid), 0);
    chk(rq, "miss req_ready low", 32'(req_ready), 0);
    chk(rq, "miss read addr", mem_req_addr, m_base + {10'b0, vpn, 2'b00});
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(rq, "stall hold valid", 32'(mem_req_valid), 1);
      chk(rq, "stall hold addr", mem_req_addr, m_base + {10'b0, vpn, 2'b00});
    end
    d = rd(mem_req_addr);
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    chk(rq, "single read", 32'(mem_req_valid), 0);
    chk(rq, "busy req_ready", 32'(req_ready), 0);
    if (wr_mid) begin
      cfg_we = 1'b1; cfg_wdata = wr_val;
      @(negedge clk);
      cfg_we = 1'b0; m_flush(wr_val); stale = 1;
    end
    mem_rsp_valid = 1'b1; mem_rsp_data = d;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    chk(rq, "walk rsp_valid", 32'(rsp_valid), 1);
    chk(rq, "walk req_ready", 32'(req_ready), 1);
    if (d[1]) begin
      exp_pa = {d[31:12], va[11:0]};
      chk(rq, "walk addr", rsp_addr, exp_pa);
      chk(rq, "walk nonsec", 32'(rsp_ns), 32'(d[3]));
      chk(rq, "walk fault", 32'(rsp_fault), 0);
      if (!stale) begin
        m_vpn[m_ptr] = vpn; m_desc[m_ptr] = d; m_v[m_ptr] = 1'b1;
        m_ptr = (m_ptr + 1) % 8;
      end
    end else begin
      chk(rq, "fault flag", 32'(rsp_fault), 1);
      chk(rq, "fault va", rsp_addr, va);
      chk(rq, "fault nonsec", 32'(rsp_ns), 0);
    end
    @(negedge clk);
    chk(rq, "rsp pulse", 32'(rsp_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    bit [31:0] b0 = 32'h0040_0000;
    bit [31:0] b1 = 32'h0100_0000;
    for (int v = 0; v < 16; v++) begin
      mem[b0 + v*4] = ((32'h80000 + v*3) << 12) | 32'h2 | ((v % 2) ? 32'h8 : 32'h0);
      mem[b1 + v*4] = ((32'h30000 + v) << 12) | 32'h2;
    end
    mem[b0 + 21*4] = 32'h1234_5008;  // valid bit clear, not zero
    for (int i = 0; i < 8; i++) m_v[i] = 1'b0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "req_ready", 32'(req_ready), 1);
    chk("R1", "rsp_valid", 32'(rsp_valid), 0);
    chk("R1", "mem_req_valid", 32'(mem_req_valid), 0);

    cfg_write(b0);
    xlate(32'h0000_0abc, "R1", 0, 0, 0, 0, 0);      // R1 first request misses
    xlate(32'h0000_0123, "R5", 0, 0, 0, 0, 1);      // R5 hit, other offset
    for (int v = 1; v < 8; v++) xlate({v[19:0], 12'h5a4}, "R3", 0, 0, 0, 0, 0);
    for (int v = 0; v < 8; v++) xlate({v[19:0], 12'hfff}, "R5", 0, 0, 0, 0, 1);
    xlate({20'd8, 12'h010}, "R7", 0, 0, 0, 0, 0);   // R7 evicts page 0
    xlate({20'd0, 12'h020}, "R7", 0, 0, 0, 0, 0);   // R7 page 0 gone, evicts page 1
    xlate({20'd2, 12'h030}, "R7", 0, 0, 0, 0, 1);   // R7 page 2 kept
    xlate({20'd1, 12'h040}, "R7", 0, 0, 0, 0, 0);
    xlate({20'd20, 12'h777}, "R4", 0, 0, 0, 0, 0);  // R4 zero descriptor
    xlate({20'd20, 12'h778}, "R4", 0, 0, 0, 0, 0);  // R4 not cached
    xlate({20'd21, 12'h001}, "R4", 0, 0, 0, 0, 0);
    xlate({20'd9, 12'h100}, "R2", 3, 0, 0, 0, 0);   // R2 delayed acceptance
    xlate({20'd9, 12'h101}, "R6", 0, 0, 0, 0, 1);   // R6 after single walk
    cfg_write(b1);                                   // R8 flush, new base
    xlate({20'd2, 12'h0aa}, "R8", 0, 0, 0, 0, 0);
    xlate({20'd3, 12'h0bb}, "R8", 0, 0, 0, 0, 0);
    xlate({20'd2, 12'h0cc}, "R8", 0, 0, 0, 0, 1);
    xlate({20'd2, 12'h0dd}, "R9", 0, 1, 0, b0, 0);  // R9 cached page, write same cycle
    xlate({20'd4, 12'h0ee}, "R10", 1, 0, 1, b0, 0); // R10 write during walk
    xlate({20'd4, 12'h0ef}, "R10", 0, 0, 0, 0, 0);  // R10 result was not cached
    xlate({20'd4, 12'h0f0}, "R10", 0, 0, 0, 0, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule